// File: doc/BRIEF.md
# Register-Mediated Memory Fetch/Store Unit

This block is a small word-addressable RAM that cannot be reached directly. Every access goes through two registers: an address holding register and a data holding register. A sequencing controller runs each access in order. The requester raises a fetch or a store strobe for one cycle, together with an address and, for a store, the data to write.

In the first cycle the controller captures the address, plus the write data on a store. In the second cycle the array is accessed through a decoder driven by the address register. A fetch copies the selected cell into the data register. A store copies the data register into the selected cell. In the third cycle the controller raises a one-cycle done flag. The read-data output always shows the data register.

Each cell is 8 bits wide, and an N-bit unsigned address selects one of 2^N cells. Every cell takes the same number of cycles to reach.

Top module: `mem_fetch_store_unit`

## Requirements
- R1: After reset, `rdata_o` (the data register) reads 0 and `done_o` is low. The address register is also cleared to 0.
- R2: A store writes `wdata_i` into the cell selected by `addr_i`. A later fetch of that address returns that 8-bit value.
- R3: When a fetch is accepted at rising edge n, `rdata_o` shows the addressed cell's value from edge n+1 onward. `done_o` is high only between edges n+1 and n+2.
- R4: When a store is accepted at rising edge n, `rdata_o` shows the stored value from edge n onward. `done_o` is high only between edges n+1 and n+2.
- R5: A fetch or store strobe that arrives while an access is in progress has no effect. This holds in the two cycles after acceptance. Such a strobe writes no cell, leaves `rdata_o` unchanged and produces no extra done pulse.
- R6: If `fetch_i` and `store_i` are both high in an accepted cycle, a store is performed and no fetch takes place.
- R7: `done_o` is never high in two consecutive cycles.
- R8: Every address from 0 to 2^N-1 selects its own cell. Writing one cell leaves all the others unchanged, including the lowest and the highest address.
- R9: Reset does not clear the memory cells. A value stored before a reset is returned by a fetch after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Cell address, captured into the address register on acceptance |
| wdata_i | input | DATA_W | Store data, captured into the data register on an accepted store |
| fetch_i | input | 1 | Fetch command strobe |
| store_i | input | 1 | Store command strobe (wins over fetch) |
| rdata_o | output | DATA_W | Contents of the data register |
| done_o | output | 1 | One-cycle pulse in the completion cycle |

## Verification
A command accepted at edge n has fixed result times. On a store, the data register holds the write data just after edge n. On a fetch, it holds the cell value just after edge n+1. Done is high only in the cycle after edge n+1.

The bench drives strobes at the falling edge before edge n. It then checks done and read data at each of the three following falling edges, so that every sample falls half a cycle after the register that produces it. Strobes injected during those three cycles are checked afterwards by fetching the addresses they named.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FINISH = 2'd2
  } seq_state_t;

  typedef enum logic {
    OP_FETCH = 1'b0,
    OP_STORE = 1'b1
  } mem_op_t;

  // Store has priority when both strobes are raised together.
  function automatic mem_op_t pick_op(input logic fetch, input logic store);
    return store ? OP_STORE : OP_FETCH;
  endfunction

endpackage

// File: rtl/mfs_sequencer.sv
module mfs_sequencer
  import mfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_i,
  input  logic store_i,
  output logic accept_o,
  output logic load_wdata_o,
  output logic rd_fire_o,
  output logic wr_fire_o,
  output logic busy_o,
  output logic done_o
);

  seq_state_t state_q;
  mem_op_t    op_q;
  mem_op_t    op_new;

  assign op_new       = pick_op(fetch_i, store_i);
  assign accept_o     = (state_q == ST_IDLE) && (fetch_i || store_i);
  assign load_wdata_o = accept_o && (op_new == OP_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_FETCH;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q <= ST_ACCESS;
            op_q    <= op_new;
          end
        end
        ST_ACCESS: state_q <= ST_FINISH;
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_fire_o = (state_q == ST_ACCESS) && (op_q == OP_FETCH);
  assign wr_fire_o = (state_q == ST_ACCESS) && (op_q == OP_STORE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FINISH);

endmodule

// File: rtl/mfs_addr_data_regs.sv
module mfs_addr_data_regs #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_wdata_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_cell_i,
  input  logic [DATA_W-1:0] cell_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o
);

  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
    end else if (load_addr_i) begin
      mar_q <= addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q <= '0;
    end else if (load_wdata_i) begin
      mdr_q <= wdata_i;
    end else if (load_cell_i) begin
      mdr_q <= cell_i;
    end
  end

  assign mar_o = mar_q;
  assign mdr_o = mdr_q;

endmodule

// File: rtl/mfs_cell_array.sv
module mfs_cell_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] sel_addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [DEPTH-1:0] decode_row(input logic [ADDR_W-1:0] a);
    logic [DEPTH-1:0] r;
    r    = '0;
    r[a] = 1'b1;
    return r;
  endfunction

  logic [DEPTH-1:0]  row_sel;
  logic [DATA_W-1:0] cell_bus [DEPTH];

  assign row_sel = decode_row(sel_addr_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (wr_en_i && row_sel[g]) begin
        cell_q <= wr_data_i;
      end
    end
    assign cell_bus[g] = cell_q;
  end

  assign rd_data_o = cell_bus[sel_addr_i];

endmodule

// File: rtl/mem_fetch_store_unit.sv
module mem_fetch_store_unit #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fetch_i,
  input  logic              store_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);

  // Named internal events, brought out for the checker.
  logic              accept_w;
  logic              load_wdata_w;
  logic              rd_fire_w;
  logic              wr_fire_w;
  logic              busy_w;
  logic [ADDR_W-1:0] mar_w;
  logic [DATA_W-1:0] mdr_w;
  logic [DATA_W-1:0] cell_rd_w;

  mfs_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_i      (fetch_i),
    .store_i      (store_i),
    .accept_o     (accept_w),
    .load_wdata_o (load_wdata_w),
    .rd_fire_o    (rd_fire_w),
    .wr_fire_o    (wr_fire_w),
    .busy_o       (busy_w),
    .done_o       (done_o)
  );

  mfs_addr_data_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_addr_i  (accept_w),
    .addr_i       (addr_i),
    .load_wdata_i (load_wdata_w),
    .wdata_i      (wdata_i),
    .load_cell_i  (rd_fire_w),
    .cell_i       (cell_rd_w),
    .mar_o        (mar_w),
    .mdr_o        (mdr_w)
  );

  mfs_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk        (clk),
    .sel_addr_i (mar_w),
    .wr_en_i    (wr_fire_w),
    .wr_data_i  (mdr_w),
    .rd_data_o  (cell_rd_w)
  );

  assign rdata_o = mdr_w;

endmodule

// File: rtl/mfs_checker.sv
module mfs_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_i,
  input logic              store_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              done_o,
  input logic              accept_w,
  input logic              rd_fire_w,
  input logic              wr_fire_w,
  input logic              busy_w,
  input logic [ADDR_W-1:0] mar_w,
  input logic [DATA_W-1:0] cell_rd_w
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rdata_o == '0 && !done_o && mar_w == '0));

  assert_fetch_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire_w |=> (rdata_o == $past(cell_rd_w)));

  assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> ##2 done_o);

  assert_store_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && store_i) |=> (rdata_o == $past(wdata_i)));

  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> !accept_w);

  assert_mdr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_w && !rd_fire_w) |=> $stable(rdata_o));

  assert_store_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && fetch_i && store_i) |=> (wr_fire_w && !rd_fire_w));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind mem_fetch_store_unit mfs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_i   (fetch_i),
  .store_i   (store_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .done_o    (done_o),
  .accept_w  (accept_w),
  .rd_fire_w (rd_fire_w),
  .wr_fire_w (wr_fire_w),
  .busy_w    (busy_w),
  .mar_w     (mar_w),
  .cell_rd_w (cell_rd_w)
);

// File: tb/tb_mem_fetch_store_unit.sv
module tb_mem_fetch_store_unit;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          fetch_i = 1'b0;
  logic          store_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic          done_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] model [DEPTH];

  always #5 clk = ~clk;

  mem_fetch_store_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .fetch_i(fetch_i), .store_i(store_i), .rdata_o(rdata_o), .done_o(done_o)
  );

  // Restated independently: store wins, else fetch.
  function automatic bit is_store(input bit f, input bit s);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One accepted command: strobes set at the falling edge before edge n.
  task automatic run_op(input bit f, input bit s, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string req);
    logic [DW-1:0] prev_mdr;
    logic [DW-1:0] exp_v;
    prev_mdr = rdata_o;
    @(negedge clk);
    addr_i = a; wdata_i = d; fetch_i = f; store_i = s;
    @(negedge clk);              // after edge n
    fetch_i = 0; store_i = 0;
    chk(done_o == 1'b0, {req, " done low after accept"}, done_o, 0);
    if (is_store(f, s)) begin
      model[a] = d;
      chk(rdata_o == d, {req, " R4 mdr holds store data"}, rdata_o, d);
    end else begin
      chk(rdata_o == prev_mdr, {req, " R3 mdr unchanged before access"}, rdata_o, prev_mdr);
    end
    exp_v = model[a];
    @(negedge clk);              // after edge n+1
    chk(done_o == 1'b1, {req, " R3 done high"}, done_o, 1);
    chk(rdata_o == exp_v, {req, " R2 data value"}, rdata_o, exp_v);
    @(negedge clk);              // after edge n+2
    chk(done_o == 1'b0, {req, " R7 done single cycle"}, done_o, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] keep;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(rdata_o == '0, "R1 mdr reset", rdata_o, 0);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata_o == '0, "R1 mdr after release", rdata_o, 0);

    // R8: fill every cell with a distinct pattern, then read extremes.
    for (int i = 0; i < DEPTH; i++) run_op(0, 1, i[AW-1:0], 8'(i * 3 + 1), "R8 fill");
    run_op(1, 0, '0, 8'h00, "R8 lowest");
    run_op(1, 0, '1, 8'h00, "R8 highest");
    run_op(0, 1, '1, 8'hA5, "R8 write top");
    run_op(1, 0, '0, 8'h00, "R8 low untouched");
    run_op(1, 0, AW'(DEPTH - 2), 8'h00, "R8 neighbour untouched");

    // R6: both strobes -> store.
    run_op(1, 1, 6'd10, 8'h5C, "R6 both strobes");
    run_op(1, 0, 6'd10, 8'h00, "R6 readback");

    // R5: strobes while busy are ignored.
    @(negedge clk);
    addr_i = 6'd20; wdata_i = 8'h77; store_i = 1;
    @(negedge clk);
    model[20] = 8'h77;
    addr_i = 6'd21; wdata_i = 8'hEE; store_i = 1; fetch_i = 1;
    @(negedge clk);
    chk(done_o == 1'b1, "R5 done of first op", done_o, 1);
    chk(rdata_o == 8'h77, "R5 mdr not overwritten", rdata_o, 8'h77);
    addr_i = 6'd22; wdata_i = 8'hDD;
    @(negedge clk);
    store_i = 0; fetch_i = 0;
    chk(done_o == 1'b0, "R5 no extra done", done_o, 0);
    chk(rdata_o == 8'h77, "R5 mdr held", rdata_o, 8'h77);
    @(negedge clk);
    chk(done_o == 1'b0, "R5 no late done", done_o, 0);
    run_op(1, 0, 6'd21, 8'h00, "R5 cell 21 untouched");
    run_op(1, 0, 6'd22, 8'h00, "R5 cell 22 untouched");

    // Random mix.
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] ra;
      logic [DW-1:0] rd;
      int sel;
      ra  = AW'($urandom());
      rd  = DW'($urandom());
      sel = $urandom_range(0, 2);
      run_op(sel != 1, sel != 0, ra, rd, "R2 random");
    end

    // R9: memory survives reset.
    run_op(0, 1, 6'd33, 8'h9B, "R9 prestore");
    keep = model[33];
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(rdata_o == '0, "R1 mdr cleared on reset", rdata_o, 0);
    rst_n = 1;
    run_op(1, 0, 6'd33, 8'h00, "R9 after reset");
    chk(rdata_o == keep, "R9 value kept", rdata_o, keep);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule